// File: doc/BRIEF.md
# Traced Byte-Enable Scratch RAM

A synchronous scratch memory for an I/O-processor subsystem model. It has one read port and one write port, and both can act in the same cycle. The write port takes a 32-bit word with a 4-bit lane strobe, so any subset of the four bytes can change in one access. A read is requested for one clock. The stored word and `rd_valid` appear in the cycle after that clock. After reset every location reads as zero. The reset clears a per-word "filled" flag and does not sweep the storage array itself.

Each completed access also produces one trace record on a side channel. The record holds a unit code, an access kind, four 64-bit argument words and a 32-bit flag word. It tags the access with a fixed region code and with the 8-bit master identifier the caller presents. A master value of 0 marks a direct test access, and other values mark processor-originated accesses. Records leave in access order and are one cycle long.

Event ordering is managed by a two-state sequencer:
- `HOLD_EMPTY` means that no record is waiting.
- `HOLD_FULL` means that one record sits in the holding register.
- Transition `T_SPLIT` (HOLD_EMPTY to HOLD_FULL) happens on a cycle with both a read and a write. The read record goes out first and the write record is parked.
- Transition `T_CHAIN` (HOLD_FULL to HOLD_FULL) happens on a single access. The parked record goes out and the new one is parked.
- Transition `T_DRAIN` (HOLD_FULL to HOLD_EMPTY) happens on an idle cycle. The parked record goes out.

Top module: `scratch_trace_ram`

## Requirements
- R1: While reset is low, `rd_valid` and `trc_valid` stay 0 whatever the request inputs do. After any reset, every location reads as 0x0000_0000 until it is written.
- R2: Addresses are byte addresses of width log2(SIZE_BYTES), with a default of 4096 bytes. The word selected is addr[ADDR_W-1:2], and addr[1:0] has no effect on which word is read or written. A write with strobe 4'b1111 stores the full word, including the topmost word at SIZE_BYTES-4.
- R3: Strobe bit b guards byte b, which is data[8b+7:8b]. Bytes whose strobe bit is 0 keep their previous content: writing 0x1234_0000 with strobe 4'b0011 over 0xCAFE_BABE gives 0xCAFE_0000. A word never written since reset keeps zero in its unstrobed bytes.
- R4: When `rd_req` is high at a rising edge, `rd_valid` is high during the following cycle and `rd_data` holds the addressed word. After an edge with `rd_req` low, `rd_valid` is low.
- R5: A read and a write to the same word at the same edge return the word as it was before that write.
- R6: A single access with no record waiting produces exactly one record in the following cycle. That record has `trc_valid` high, `trc_unit` = 2 (I/O processor) and `trc_kind` = 1 for a read or 2 for a write.
- R7: The record fields are as follows. arg0 holds the byte address, zero-extended. arg1[31:0] holds the read data or the write data as presented, with the upper half zero. arg2 is 0. arg3[7:0] holds the region code 2. arg3[15:8] holds the master identifier sampled at the access edge, and all other bits of arg3 are 0. flags[3:0] holds the write strobe for a write and 0 for a read, and all other flag bits are 0. Every record output is 0 while `trc_valid` is low.
- R8: A cycle with both a read and a write emits the read record in the next cycle and the write record in the cycle after. Records from later accesses keep access order and follow without gaps. The caller issues a read and a write together only when no record is parked, which is the case when the previous cycle's accesses left at most one record pending.
- R9: The number of records emitted, all carrying region code 2, equals the number of reads plus the number of writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Read request for this edge |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read word, valid with rd_valid |
| rd_valid | output | 1 | High in the cycle after a read request |
| wr_req | input | 1 | Write request for this edge |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write word |
| wr_strb | input | 4 | Per-byte write strobe |
| req_master | input | 8 | Master identifier copied into the record |
| trc_valid | output | 1 | One-cycle record strobe |
| trc_unit | output | 4 | Unit code, 2 for the I/O processor |
| trc_kind | output | 2 | 1 for a read, 2 for a write |
| trc_arg0 | output | 64 | Access byte address |
| trc_arg1 | output | 64 | Read or write data |
| trc_arg2 | output | 64 | Zero |
| trc_arg3 | output | 64 | Master in [15:8], region code in [7:0] |
| trc_flags | output | 32 | Write strobe in [3:0] |

## Verification
The checker watches the following on every cycle:
- Reset quietness.
- The one-cycle link from `rd_req` to `rd_valid`.
- Legal unit and kind codes, and zeroed reserved fields and idle outputs.
- The content of a record after a lone access.
- Gapless emission against a pending-record count built from the request ports, and the bound on that count, which enforces the caller's rule.

Stored contents can only be shown by the bench's scenarios, checked against a shadow copy of the memory. These cover:
- byte-lane merging on both fresh and written words;
- the old-data result of a same-word read and write;
- wraparound use of the top word and ignored low address bits;
- exact record order after split and chained accesses;
- clearing by a second reset.

// File: rtl/str_pkg.sv
`timescale 1ns/1ps
package str_pkg;

    typedef enum logic [3:0] {
        UNIT_NONE = 4'd0,
        UNIT_MAIN = 4'd1,
        UNIT_IO   = 4'd2,
        UNIT_GFX  = 4'd3
    } unit_e;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2
    } kind_e;

    localparam logic [7:0] REGION_SCRATCH = 8'd2;

    // One access as it travels towards the trace channel.
    typedef struct packed {
        logic        vld;
        kind_e       kind;
        logic [31:0] addr;
        logic [31:0] data;
        logic [7:0]  master;
        logic [3:0]  strb;
    } acc_t;

endpackage : str_pkg

// File: rtl/str_store.sv
`timescale 1ns/1ps
module str_store #(
    parameter int SIZE_BYTES = 4096
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_req,
    input  logic [$clog2(SIZE_BYTES/4)-1:0]  rd_word,
    input  logic                             wr_req,
    input  logic [$clog2(SIZE_BYTES/4)-1:0]  wr_word,
    input  logic [31:0]                      wr_data,
    input  logic [3:0]                       wr_strb,
    output logic [31:0]                      rd_now,
    output logic [31:0]                      rd_data,
    output logic                             rd_valid
);
    localparam int WORDS  = SIZE_BYTES / 4;
    localparam int LANES  = 4;

    logic [31:0]      mem_q [WORDS];
    logic [WORDS-1:0] filled_q;
    logic [31:0]      wr_old;
    logic [31:0]      wr_merged;

    // A word never written since reset reads as zero.
    assign rd_now = filled_q[rd_word] ? mem_q[rd_word] : 32'h0;
    assign wr_old = filled_q[wr_word] ? mem_q[wr_word] : 32'h0;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign wr_merged[8*g +: 8] = wr_strb[g] ? wr_data[8*g +: 8]
                                                    : wr_old[8*g +: 8];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_req) begin
            mem_q[wr_word] <= wr_merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filled_q <= '0;
        end else if (wr_req) begin
            filled_q[wr_word] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 32'h0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                rd_data <= rd_now;
            end
        end
    end

endmodule : str_store

// File: rtl/str_sequencer.sv
`timescale 1ns/1ps
module str_sequencer
    import str_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  acc_t rd_acc,
    input  acc_t wr_acc,
    output acc_t cur_acc
);
    typedef enum logic {
        HOLD_EMPTY = 1'b0,
        HOLD_FULL  = 1'b1
    } hold_state_e;

    hold_state_e state_q, state_d;
    acc_t        hold_q, hold_d;
    acc_t        out_q, out_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HOLD_EMPTY;
            hold_q  <= '0;
            out_q   <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
            out_q   <= out_d;
        end
    end

    // Next state and next record.
    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        out_d   = '0;
        unique case (state_q)
            HOLD_EMPTY: begin
                if (rd_acc.vld && wr_acc.vld) begin
                    out_d   = rd_acc;          // T_SPLIT
                    hold_d  = wr_acc;
                    state_d = HOLD_FULL;
                end else if (rd_acc.vld) begin
                    out_d   = rd_acc;
                end else if (wr_acc.vld) begin
                    out_d   = wr_acc;
                end
            end
            HOLD_FULL: begin
                out_d = hold_q;
                if (rd_acc.vld) begin
                    hold_d = rd_acc;           // T_CHAIN
                end else if (wr_acc.vld) begin
                    hold_d = wr_acc;           // T_CHAIN
                end else begin
                    hold_d  = '0;              // T_DRAIN
                    state_d = HOLD_EMPTY;
                end
            end
            default: begin
                state_d = HOLD_EMPTY;
                hold_d  = '0;
            end
        endcase
    end

    assign cur_acc = out_q;

endmodule : str_sequencer

// File: rtl/str_format.sv
`timescale 1ns/1ps
module str_format
    import str_pkg::*;
(
    input  acc_t        cur_acc,
    output logic        trc_valid,
    output logic [3:0]  trc_unit,
    output logic [1:0]  trc_kind,
    output logic [63:0] trc_arg0,
    output logic [63:0] trc_arg1,
    output logic [63:0] trc_arg2,
    output logic [63:0] trc_arg3,
    output logic [31:0] trc_flags
);
    always_comb begin
        trc_valid = cur_acc.vld;
        trc_unit  = cur_acc.vld ? UNIT_IO : UNIT_NONE;
        trc_kind  = cur_acc.kind;
        trc_arg0  = {32'h0, cur_acc.addr};
        trc_arg1  = {32'h0, cur_acc.data};
        trc_arg2  = 64'h0;
        trc_arg3  = {48'h0, cur_acc.master,
                     (cur_acc.vld ? REGION_SCRATCH : 8'h00)};
        trc_flags = {28'h0, cur_acc.strb};
    end

endmodule : str_format

// File: rtl/scratch_trace_ram.sv
`timescale 1ns/1ps
module scratch_trace_ram
    import str_pkg::*;
#(
    parameter int SIZE_BYTES = 4096,
    parameter int ADDR_W     = $clog2(SIZE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        wr_strb,
    input  logic [7:0]        req_master,
    output logic              trc_valid,
    output logic [3:0]        trc_unit,
    output logic [1:0]        trc_kind,
    output logic [63:0]       trc_arg0,
    output logic [63:0]       trc_arg1,
    output logic [63:0]       trc_arg2,
    output logic [63:0]       trc_arg3,
    output logic [31:0]       trc_flags
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [31:0] rd_now;
    acc_t        rd_acc, wr_acc, cur_acc;

    str_store #(.SIZE_BYTES(SIZE_BYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .rd_word  (rd_addr[ADDR_W-1 -: WIDX_W]),
        .wr_req   (wr_req),
        .wr_word  (wr_addr[ADDR_W-1 -: WIDX_W]),
        .wr_data  (wr_data),
        .wr_strb  (wr_strb),
        .rd_now   (rd_now),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Build one record per requested access.
    always_comb begin
        rd_acc = '0;
        wr_acc = '0;
        if (rd_req) begin
            rd_acc.vld    = 1'b1;
            rd_acc.kind   = KIND_READ;
            rd_acc.addr   = 32'(rd_addr);
            rd_acc.data   = rd_now;
            rd_acc.master = req_master;
            rd_acc.strb   = 4'h0;
        end
        if (wr_req) begin
            wr_acc.vld    = 1'b1;
            wr_acc.kind   = KIND_WRITE;
            wr_acc.addr   = 32'(wr_addr);
            wr_acc.data   = wr_data;
            wr_acc.master = req_master;
            wr_acc.strb   = wr_strb;
        end
    end

    str_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_acc  (rd_acc),
        .wr_acc  (wr_acc),
        .cur_acc (cur_acc)
    );

    str_format u_fmt (
        .cur_acc   (cur_acc),
        .trc_valid (trc_valid),
        .trc_unit  (trc_unit),
        .trc_kind  (trc_kind),
        .trc_arg0  (trc_arg0),
        .trc_arg1  (trc_arg1),
        .trc_arg2  (trc_arg2),
        .trc_arg3  (trc_arg3),
        .trc_flags (trc_flags)
    );

endmodule : scratch_trace_ram

// File: rtl/str_chk.sv
`timescale 1ns/1ps
module str_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_req,
    input logic        wr_req,
    input logic [31:0] wr_data,
    input logic [7:0]  req_master,
    input logic [31:0] rd_data,
    input logic        rd_valid,
    input logic        trc_valid,
    input logic [3:0]  trc_unit,
    input logic [1:0]  trc_kind,
    input logic [63:0] trc_arg0,
    input logic [63:0] trc_arg1,
    input logic [63:0] trc_arg2,
    input logic [63:0] trc_arg3,
    input logic [31:0] trc_flags
);
    // Records requested at the ports but not yet retired from the output.
    logic [2:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 3'd0;
        end else begin
            pend_q <= pend_q + 3'(rd_req) + 3'(wr_req) - 3'(trc_valid);
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!trc_valid && !rd_valid); // R1
        end
    end

    AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid); // R4
    AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid); // R4
    AST_EV_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        trc_valid |-> (trc_unit == 4'd2) && (trc_kind == 2'd1 || trc_kind == 2'd2)); // R6
    AST_LONE_READ_REC: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !wr_req && pend_q <= 3'd1) |=>
        (trc_valid && trc_kind == 2'd1 && trc_arg1[31:0] == rd_data)); // R6
    AST_LONE_WRITE_REC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !rd_req && pend_q <= 3'd1) |=>
        (trc_valid && trc_kind == 2'd2 && trc_arg1[31:0] == $past(wr_data)
         && trc_arg3[15:8] == $past(req_master))); // R6
    AST_EV_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        trc_valid |-> (trc_arg2 == 64'h0) && (trc_arg3[63:16] == 48'h0)
                      && (trc_arg3[7:0] == 8'd2) && (trc_arg0[63:32] == 32'h0)
                      && (trc_arg1[63:32] == 32'h0) && (trc_flags[31:4] == 28'h0)); // R7
    AST_READ_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        (trc_valid && trc_kind == 2'd1) |-> (trc_flags == 32'h0)); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !trc_valid |-> (trc_kind == 2'd0) && (trc_unit == 4'd0) && (trc_arg0 == 64'h0)
                       && (trc_arg1 == 64'h0) && (trc_arg3 == 64'h0) && (trc_flags == 32'h0)); // R7
    AST_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
        trc_valid == (pend_q != 3'd0)); // R8
    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= 3'd2); // R8

endmodule : str_chk

bind scratch_trace_ram str_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .wr_req     (wr_req),
    .wr_data    (wr_data),
    .req_master (req_master),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .trc_valid  (trc_valid),
    .trc_unit   (trc_unit),
    .trc_kind   (trc_kind),
    .trc_arg0   (trc_arg0),
    .trc_arg1   (trc_arg1),
    .trc_arg2   (trc_arg2),
    .trc_arg3   (trc_arg3),
    .trc_flags  (trc_flags)
);

// File: tb/sim_scratch_trace_ram.sv
`timescale 1ns/1ps
module sim_scratch_trace_ram;
    localparam int SIZE_BYTES = 4096;
    localparam int ADDR_W     = $clog2(SIZE_BYTES);
    localparam int WORDS      = SIZE_BYTES / 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rd_req, wr_req;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [31:0]       wr_data, rd_data;
    logic [3:0]        wr_strb;
    logic [7:0]        req_master;
    logic              rd_valid, trc_valid;
    logic [3:0]        trc_unit;
    logic [1:0]        trc_kind;
    logic [63:0]       trc_arg0, trc_arg1, trc_arg2, trc_arg3;
    logic [31:0]       trc_flags;

    always #2 clk = ~clk;

    scratch_trace_ram #(.SIZE_BYTES(SIZE_BYTES)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .req_master(req_master),
        .trc_valid(trc_valid), .trc_unit(trc_unit), .trc_kind(trc_kind),
        .trc_arg0(trc_arg0), .trc_arg1(trc_arg1), .trc_arg2(trc_arg2),
        .trc_arg3(trc_arg3), .trc_flags(trc_flags)
    );

    typedef struct {
        logic [1:0]  kind;
        logic [31:0] addr;
        logic [31:0] data;
        logic [7:0]  master;
        logic [3:0]  strb;
    } exp_rec_t;

    exp_rec_t    recq[$];
    logic [31:0] shadow [WORDS];
    int checks = 0;
    int errors = 0;
    int n_access = 0;
    int n_records = 0;
    int cyc = 0;

    function automatic logic [31:0] merge_bytes(logic [31:0] old_w, logic [31:0] new_w,
                                                logic [3:0] strb);
        logic [31:0] r = old_w;
        for (int b = 0; b < 4; b++) begin
            if (strb[b]) r[8*b +: 8] = new_w[8*b +: 8];
        end
        return r;
    endfunction

    function automatic int widx(logic [ADDR_W-1:0] a);
        return int'(a >> 2);
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog: cycles %0d expected below %0d", cyc, 150000);
            report();
        end
    end

    task automatic check_record();
        if (recq.size() != 0) begin
            exp_rec_t e = recq.pop_front();
            n_records += (trc_valid && trc_arg3[7:0] == 8'd2) ? 1 : 0;
            check(trc_valid == 1'b1, "R8", "record present", 64'(trc_valid), 64'd1);
            check(trc_unit == 4'd2, "R6", "unit code", 64'(trc_unit), 64'd2);
            check(trc_kind == e.kind, "R6", "kind", 64'(trc_kind), 64'(e.kind));
            check(trc_arg0 == 64'(e.addr), "R7", "arg0 address", trc_arg0, 64'(e.addr));
            check(trc_arg1 == 64'(e.data), "R7", "arg1 data", trc_arg1, 64'(e.data));
            check(trc_arg2 == 64'h0, "R7", "arg2", trc_arg2, 64'h0);
            check(trc_arg3 == {48'h0, e.master, 8'd2}, "R7", "arg3 tags",
                  trc_arg3, {48'h0, e.master, 8'd2});
            check(trc_flags == 32'(e.strb), "R7", "flags", 64'(trc_flags), 64'(e.strb));
        end else begin
            check(trc_valid == 1'b0, "R8", "no record", 64'(trc_valid), 64'd0);
            check(trc_arg3 == 64'h0 && trc_flags == 32'h0, "R7", "idle fields zero",
                  trc_arg3, 64'h0);
        end
    endtask

    // One clock: drive at the falling edge, model at the rising edge, check at the next falling edge.
    task automatic step(bit r, logic [ADDR_W-1:0] ra, bit w, logic [ADDR_W-1:0] wa,
                        logic [31:0] wd, logic [3:0] ws, logic [7:0] m, string req);
        logic [31:0] exp_rd;
        rd_req = r; rd_addr = ra;
        wr_req = w; wr_addr = wa; wr_data = wd; wr_strb = ws;
        req_master = m;
        @(posedge clk);
        exp_rd = shadow[widx(ra)];
        if (r) begin
            recq.push_back('{2'd1, 32'(ra), exp_rd, m, 4'h0});
            n_access++;
        end
        if (w) begin
            shadow[widx(wa)] = merge_bytes(shadow[widx(wa)], wd, ws);
            recq.push_back('{2'd2, 32'(wa), wd, m, ws});
            n_access++;
        end
        @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0;
        check(rd_valid == r, "R4", "rd_valid", 64'(rd_valid), 64'(r));
        if (r) check(rd_data == exp_rd, req, "rd_data", 64'(rd_data), 64'(exp_rd));
        check_record();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0, 32'h0, 4'h0, 8'h0, "R4");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rd_req = 1'b1; wr_req = 1'b1; wr_strb = 4'hF; wr_data = 32'hFFFF_FFFF;
        rd_addr = '0; wr_addr = '0;
        @(posedge clk);
        @(negedge clk);
        check(rd_valid == 1'b0, "R1", "rd_valid in reset", 64'(rd_valid), 64'd0);
        check(trc_valid == 1'b0, "R1", "trc_valid in reset", 64'(trc_valid), 64'd0);
        for (int i = 0; i < WORDS; i++) shadow[i] = 32'h0;
        recq.delete();
        rd_req = 1'b0; wr_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        rd_req = 0; wr_req = 0; rd_addr = '0; wr_addr = '0;
        wr_data = '0; wr_strb = '0; req_master = '0;
        do_reset();

        // R1: cleared content
        step(1, 12'h000, 0, '0, 0, 0, 8'h00, "R1");
        // R2: full word
        step(0, '0, 1, 12'h000, 32'hCAFE_BABE, 4'hF, 8'h00, "R2");
        step(1, 12'h000, 0, '0, 0, 0, 8'h00, "R2");
        // R3: low two lanes only
        step(0, '0, 1, 12'h000, 32'h1234_0000, 4'h3, 8'h00, "R3");
        step(1, 12'h000, 0, '0, 0, 0, 8'h00, "R3");
        // R3: partial write to a fresh word
        step(0, '0, 1, 12'h040, 32'h55AB_6677, 4'h4, 8'h00, "R3");
        step(1, 12'h040, 0, '0, 0, 0, 8'h00, "R3");
        // R2: low address bits ignored, master tag per R7
        step(0, '0, 1, 12'h010, 32'hDEAD_BEEF, 4'hF, 8'h02, "R2");
        step(1, 12'h013, 0, '0, 0, 0, 8'h02, "R2");
        // R5 and R8: same word read and write, then a chained read
        step(1, 12'h010, 1, 12'h010, 32'h1122_3344, 4'hF, 8'h05, "R5");
        step(1, 12'h010, 0, '0, 0, 0, 8'h05, "R5");
        idle(2);
        // R2: topmost word
        step(0, '0, 1, ADDR_W'(SIZE_BYTES - 4), 32'h0BAD_F00D, 4'hF, 8'h01, "R2");
        step(1, ADDR_W'(SIZE_BYTES - 4), 0, '0, 0, 0, 8'h01, "R2");
        step(1, 12'h020, 0, '0, 0, 0, 8'h00, "R1");

        // Random mix over a small window to force collisions (R8 order).
        for (int i = 0; i < 4000; i++) begin
            bit r = ($urandom % 100) < 45;
            bit w = ($urandom % 100) < 45;
            logic [ADDR_W-1:0] ra = ADDR_W'($urandom % 64);
            logic [ADDR_W-1:0] wa = ADDR_W'($urandom % 64);
            if (($urandom % 8) == 0) ra = ADDR_W'($urandom);
            if (($urandom % 6) == 0) wa = ra;
            if (r && w && recq.size() != 0) w = 1'b0;
            step(r, ra, w, wa, $urandom, 4'($urandom), 8'($urandom), "R3");
        end
        idle(3);
        check(n_records == n_access, "R9", "region-tagged records vs accesses",
              64'(n_records), 64'(n_access));

        // R1: second reset clears written words
        do_reset();
        step(1, 12'h010, 0, '0, 0, 0, 8'h00, "R1");
        step(1, ADDR_W'(SIZE_BYTES - 4), 0, '0, 0, 0, 8'h00, "R1");
        idle(1);
        report();
    end

endmodule : sim_scratch_trace_ram